// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sits on the host side of a PS/2 keyboard link and sends one 8-bit command byte to the device. The host logic presents a byte with a one-cycle send strobe. If the device is already sending a frame, the block waits until the bus has been quiet for a set time. It then pulls the clock line low for a timed inhibit. After the inhibit it drives the start bit and releases the clock. The device then generates the clock pulses. On each falling edge of the device clock the block moves to the next bit: eight data bits least significant first, an odd parity bit, then a released (high) stop bit. On the following falling edge it samples the device acknowledge. It ends with a one-cycle done or error pulse.

The two open-drain lines are modelled as a line input plus an output enable. When an enable is high, the line is pulled low. When it is low, the line floats high. All line inputs pass through a two-stage synchronizer. Timing is derived from a parameter that gives the system clock frequency. The same counters measure the bus-quiet time, the inhibit time and two timeouts. If no device clock edge arrives within the request timeout, or if the gap between device clock edges exceeds the edge timeout, the block abandons the transfer, releases both lines and reports an error.

Top module: `ps2_cmd_tx`

## Requirements
- R1: After reset, both output enables, busy, done and error are low, and they stay low until a send strobe arrives.
- R2: A send strobe that arrives while busy is low starts a transfer, and busy is high from the next cycle until the cycle that carries the done or error pulse.
- R3: While the device clock line is toggling, the block never drives the clock. It begins its inhibit only after the clock line has stayed high for QUIET_US microseconds without a break.
- R4: The clock enable stays high for INHIBIT_US microseconds in a single run. This is never less than 60 us. The data enable is low during the inhibit.
- R5: In the cycle where the inhibit ends, the clock enable falls and the data enable rises, which drives the start bit as 0.
- R6: The data enable changes only one cycle after a detected falling edge of the synchronized device clock. The exceptions are the start of the frame and an abort. The eight data bits appear least significant bit first, and data enable high means a 0 bit.
- R7: After the eighth data bit comes a parity bit that makes the total count of ones across data and parity odd.
- R8: After the tenth falling edge of the device clock, the data line is released, which gives a stop bit of 1.
- R9: On the eleventh falling edge of the device clock, a low data line gives a done pulse, and a high data line gives an error pulse instead.
- R10: If the device has not produced its first clock edge within REQ_TMO_US microseconds of the send strobe, the block raises an error and releases both lines. The bench parameters give 15 ms.
- R11: If the device clock stays idle for EDGE_TMO_US microseconds after any edge during a frame, the block raises an error and releases both lines. The bench parameters give 2 ms.
- R12: Done and error are single-cycle pulses that are never high together. Both line enables are low from the cycle of the pulse onward.
- R13: A send strobe that arrives while busy is high has no effect. The byte in flight is sent unchanged, and no second transfer follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_data | input | 8 | Command byte to send, captured on the send strobe |
| tx_send | input | 1 | One-cycle request to send tx_data |
| busy | output | 1 | A transfer is pending or in progress |
| tx_done | output | 1 | One-cycle pulse: the device acknowledged the byte |
| tx_err | output | 1 | One-cycle pulse: no acknowledge, or a timeout |
| ps2_clk_i | input | 1 | Sensed level of the PS/2 clock line |
| ps2_dat_i | input | 1 | Sensed level of the PS/2 data line |
| ps2_clk_oe | output | 1 | High pulls the clock line low |
| ps2_dat_oe | output | 1 | High pulls the data line low |

## Verification
The assertions assume that the device holds each clock level for well over three system cycles. This lets every falling edge pass the synchronizer and be seen exactly once. They also assume that the send strobe is a clean synchronous pulse. The bench device model keeps its clock low for 30 cycles and high for at least 20 cycles at a 1 MHz system clock. It changes data only around its own clock edges, and it pulses the send strobe on a falling edge of the system clock for one cycle.

// File: rtl/ps2_cmd_tx_pkg.sv
package ps2_cmd_tx_pkg;

  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 3;          // start, data, parity, stop
  localparam int BCNT_W  = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEFER,
    S_INHIBIT,
    S_START,
    S_SHIFT,
    S_ACK
  } tx_state_e;

  function automatic logic odd_parity(input logic [DATA_W-1:0] d);
    return ~^d;
  endfunction

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_line,
  input  logic dat_line,
  output logic clk_s,
  output logic dat_s,
  output logic clk_fall
);

  logic [2:0] clk_sh_q, clk_sh_n;
  logic [1:0] dat_sh_q, dat_sh_n;

  always_comb begin
    clk_sh_n = {clk_sh_q[1:0], clk_line};
    dat_sh_n = {dat_sh_q[0], dat_line};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sh_q <= 3'b111;
      dat_sh_q <= 2'b11;
    end else begin
      clk_sh_q <= clk_sh_n;
      dat_sh_q <= dat_sh_n;
    end
  end

  assign clk_s    = clk_sh_q[1];
  assign dat_s    = dat_sh_q[1];
  assign clk_fall = clk_sh_q[2] & ~clk_sh_q[1];

endmodule

// File: rtl/ps2_tick_counter.sv
module ps2_tick_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  assign cnt_en = clr | (cnt_q != TOP);

  always_comb begin
    if (clr) cnt_n = '0;
    else     cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;

  // R10 / R11: a timeout counter must never wrap back to a small value
  a_r10_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TOP && !clr) |=> (cnt_q == TOP));

endmodule

// File: rtl/ps2_tx_fsm.sv
module ps2_tx_fsm
  import ps2_cmd_tx_pkg::*;
#(
  parameter int CW          = 16,
  parameter int QUIET_CYC   = 100,
  parameter int INHIBIT_CYC = 100,
  parameter int REQ_CYC     = 15000,
  parameter int EDGE_CYC    = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_send,
  input  logic              clk_s,
  input  logic              dat_s,
  input  logic              clk_fall,
  input  logic [CW-1:0]     ph_cnt,
  input  logic [CW-1:0]     rq_cnt,
  output logic              ph_clr,
  output logic              rq_clr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              clk_oe,
  output logic              dat_oe
);

  localparam logic [CW-1:0]     QUIET_L = CW'(QUIET_CYC - 1);
  localparam logic [CW-1:0]     INH_L   = CW'(INHIBIT_CYC - 1);
  localparam logic [CW-1:0]     REQ_L   = CW'(REQ_CYC - 1);
  localparam logic [CW-1:0]     EDGE_L  = CW'(EDGE_CYC - 1);
  localparam logic [BCNT_W-1:0] LAST_B  = BCNT_W'(FRAME_W - 2);

  tx_state_e            st_q, st_n;
  logic [FRAME_W-1:0]   sh_q, sh_n;
  logic [BCNT_W-1:0]    bc_q, bc_n;
  logic                 clk_oe_q, clk_oe_n;
  logic                 dat_oe_q, dat_oe_n;
  logic                 done_q, done_n;
  logic                 err_q, err_n;
  logic                 req_late, edge_late, abort;

  assign req_late  = (st_q == S_DEFER || st_q == S_INHIBIT || st_q == S_START) &&
                     (rq_cnt >= REQ_L);
  assign edge_late = (st_q == S_SHIFT || st_q == S_ACK) && (ph_cnt >= EDGE_L);
  assign abort     = req_late | edge_late;
  assign rq_clr    = (st_q == S_IDLE);

  always_comb begin
    st_n     = st_q;
    sh_n     = sh_q;
    bc_n     = bc_q;
    clk_oe_n = clk_oe_q;
    dat_oe_n = dat_oe_q;
    done_n   = 1'b0;
    err_n    = 1'b0;
    ph_clr   = 1'b0;
    if (abort) begin
      st_n     = S_IDLE;
      clk_oe_n = 1'b0;
      dat_oe_n = 1'b0;
      err_n    = 1'b1;
      ph_clr   = 1'b1;
    end else begin
      case (st_q)
        S_IDLE: begin
          ph_clr = 1'b1;
          if (tx_send) begin
            sh_n = {1'b1, odd_parity(tx_data), tx_data, 1'b0};
            st_n = S_DEFER;
          end
        end
        S_DEFER: begin
          if (!clk_s) begin
            ph_clr = 1'b1;
          end else if (ph_cnt >= QUIET_L) begin
            st_n     = S_INHIBIT;
            clk_oe_n = 1'b1;
            ph_clr   = 1'b1;
          end
        end
        S_INHIBIT: begin
          if (ph_cnt >= INH_L) begin
            st_n     = S_START;
            clk_oe_n = 1'b0;
            dat_oe_n = ~sh_q[0];
            bc_n     = '0;
            ph_clr   = 1'b1;
          end
        end
        S_START, S_SHIFT: begin
          if (clk_fall) begin
            sh_n     = {1'b1, sh_q[FRAME_W-1:1]};
            dat_oe_n = ~sh_q[1];
            bc_n     = bc_q + BCNT_W'(1);
            ph_clr   = 1'b1;
            st_n     = (bc_q == LAST_B) ? S_ACK : S_SHIFT;
          end
        end
        S_ACK: begin
          if (clk_fall) begin
            st_n     = S_IDLE;
            clk_oe_n = 1'b0;
            dat_oe_n = 1'b0;
            done_n   = ~dat_s;
            err_n    = dat_s;
            ph_clr   = 1'b1;
          end
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      sh_q     <= '1;
      bc_q     <= '0;
      clk_oe_q <= 1'b0;
      dat_oe_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st_q     <= st_n;
      sh_q     <= sh_n;
      bc_q     <= bc_n;
      clk_oe_q <= clk_oe_n;
      dat_oe_q <= dat_oe_n;
      done_q   <= done_n;
      err_q    <= err_n;
    end
  end

  assign busy   = (st_q != S_IDLE);
  assign done   = done_q;
  assign err    = err_q;
  assign clk_oe = clk_oe_q;
  assign dat_oe = dat_oe_q;

  a_r1_idle_lines_free: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!clk_oe_q && !dat_oe_q));

  a_r2_send_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_send && !busy) |=> busy);

  a_r4_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_oe_q && dat_oe_q));

  a_r5_release_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_oe_q) |-> (dat_oe_q || err_q));

  a_r6_data_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dat_oe_q) |-> ($past(clk_fall) || $fell(clk_oe_q) || err_q));

  a_r9_done_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(st_q) == S_ACK));

  a_r12_done_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && err_q));

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q || err_q) |=> (!done_q && !err_q));

endmodule

// File: rtl/ps2_cmd_tx.sv
module ps2_cmd_tx
  import ps2_cmd_tx_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int QUIET_US    = 100,
  parameter int INHIBIT_US  = 100,
  parameter int REQ_TMO_US  = 15000,
  parameter int EDGE_TMO_US = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_send,
  output logic              busy,
  output logic              tx_done,
  output logic              tx_err,
  input  logic              ps2_clk_i,
  input  logic              ps2_dat_i,
  output logic              ps2_clk_oe,
  output logic              ps2_dat_oe
);

  localparam int CYC_PER_US  = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int QUIET_CYC   = QUIET_US * CYC_PER_US;
  localparam int INHIBIT_CYC = INHIBIT_US * CYC_PER_US;
  localparam int REQ_CYC     = REQ_TMO_US * CYC_PER_US;
  localparam int EDGE_CYC    = EDGE_TMO_US * CYC_PER_US;
  localparam int MAX_AB      = (QUIET_CYC > INHIBIT_CYC) ? QUIET_CYC : INHIBIT_CYC;
  localparam int MAX_CD      = (REQ_CYC > EDGE_CYC) ? REQ_CYC : EDGE_CYC;
  localparam int MAX_CYC     = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW          = $clog2(MAX_CYC + 1);

  logic [1:0]    rsync_q;
  logic          rst_ns;
  logic          clk_s, dat_s, clk_fall;
  logic          ph_clr, rq_clr;
  logic [CW-1:0] ph_cnt, rq_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  ps2_line_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_ns),
    .clk_line (ps2_clk_i),
    .dat_line (ps2_dat_i),
    .clk_s    (clk_s),
    .dat_s    (dat_s),
    .clk_fall (clk_fall)
  );

  ps2_tick_counter #(.CW(CW)) u_phase_cnt (
    .clk   (clk),
    .rst_n (rst_ns),
    .clr   (ph_clr),
    .cnt   (ph_cnt)
  );

  ps2_tick_counter #(.CW(CW)) u_req_cnt (
    .clk   (clk),
    .rst_n (rst_ns),
    .clr   (rq_clr),
    .cnt   (rq_cnt)
  );

  ps2_tx_fsm #(
    .CW          (CW),
    .QUIET_CYC   (QUIET_CYC),
    .INHIBIT_CYC (INHIBIT_CYC),
    .REQ_CYC     (REQ_CYC),
    .EDGE_CYC    (EDGE_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_ns),
    .tx_data  (tx_data),
    .tx_send  (tx_send),
    .clk_s    (clk_s),
    .dat_s    (dat_s),
    .clk_fall (clk_fall),
    .ph_cnt   (ph_cnt),
    .rq_cnt   (rq_cnt),
    .ph_clr   (ph_clr),
    .rq_clr   (rq_clr),
    .busy     (busy),
    .done     (tx_done),
    .err      (tx_err),
    .clk_oe   (ps2_clk_oe),
    .dat_oe   (ps2_dat_oe)
  );

endmodule

// File: tb/tb_ps2_cmd_tx.sv
module tb_ps2_cmd_tx;

  localparam int CLK_PERIOD = 1000;   // 1 MHz system clock, units of 1 ns
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] tx_data;
  logic       tx_send;
  logic       busy, tx_done, tx_err;
  logic       ps2_clk_oe, ps2_dat_oe;
  logic       dev_clk_low, dev_dat_low;
  logic       clk_line, dat_line;

  assign clk_line = ~(ps2_clk_oe | dev_clk_low);
  assign dat_line = ~(ps2_dat_oe | dev_dat_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_cmd_tx #(.CLK_HZ(1_000_000)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_data    (tx_data),
    .tx_send    (tx_send),
    .busy       (busy),
    .tx_done    (tx_done),
    .tx_err     (tx_err),
    .ps2_clk_i  (clk_line),
    .ps2_dat_i  (dat_line),
    .ps2_clk_oe (ps2_clk_oe),
    .ps2_dat_oe (ps2_dat_oe)
  );

  int total = 0, fails = 0, cyc = 0;
  int done_cnt = 0, err_cnt = 0;
  int inh_run = 0, last_inh = 0, inh_cnt = 0, viol = 0;
  bit start_ok = 0, dev_frame_active = 0;

  always @(negedge clk) begin
    cyc++;
    if (tx_done) done_cnt++;
    if (tx_err)  err_cnt++;
    if (ps2_clk_oe) inh_run++;
    else if (inh_run != 0) begin
      last_inh = inh_run; inh_run = 0; inh_cnt++; start_ok = ps2_dat_oe;
    end
    if (dev_frame_active && ps2_clk_oe) viol++;
    if (cyc == WATCHDOG) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_send = 1'b1;
    @(negedge clk); tx_send = 1'b0;
  endtask

  // Device side of a host-to-device frame: waits for the start condition,
  // then clocks nclk pulses, sampling data at each rising edge.
  task automatic dev_respond(input int nclk, input bit ack,
                             output logic [10:0] bits, output bit seen);
    bits = '1; seen = 0;
    for (int w = 0; w < 20000 && !seen; w++) begin
      @(negedge clk);
      if (!dat_line && clk_line && ps2_dat_oe) seen = 1;
    end
    if (!seen) return;
    bits[0] = dat_line;
    for (int k = 1; k <= nclk; k++) begin
      repeat (20) @(negedge clk);
      dev_clk_low = 1'b1;
      repeat (30) @(negedge clk);
      dev_clk_low = 1'b0;
      if (k <= 10) bits[k] = dat_line;
      if (k == 10 && ack) begin repeat (5) @(negedge clk); dev_dat_low = 1'b1; end
      if (k == 11) dev_dat_low = 1'b0;
    end
  endtask

  task automatic full_tx(input logic [7:0] b);
    logic [10:0] bits; bit seen; int d0, e0;
    d0 = done_cnt; e0 = err_cnt;
    send(b);
    dev_respond(11, 1, bits, seen);
    repeat (6) @(negedge clk);
    chk(seen, "R5", "start condition seen", seen, 1);
    chk(start_ok, "R5", "data driven when clock released", start_ok, 1);
    chk(last_inh >= 60 && last_inh == 100, "R4", "inhibit cycles", last_inh, 100);
    chk(bits[0] == 1'b0, "R5", "start bit", bits[0], 0);
    chk(bits[8:1] == b, "R6", "data byte lsb first", bits[8:1], b);
    chk(bits[9] == ~^b, "R7", "odd parity bit", bits[9], ~^b);
    chk(bits[10] == 1'b1, "R8", "stop bit", bits[10], 1);
    chk(done_cnt - d0 == 1 && err_cnt == e0, "R9", "done pulses", done_cnt - d0, 1);
    chk(!ps2_clk_oe && !ps2_dat_oe && !busy, "R12", "lines released after done",
        {ps2_clk_oe, ps2_dat_oe, busy}, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !tx_done && !tx_err && !ps2_clk_oe && !ps2_dat_oe, "R1",
        "reset outputs", {busy, tx_done, tx_err, ps2_clk_oe, ps2_dat_oe}, 0);
    repeat (200) @(negedge clk);
    chk(!busy && !ps2_clk_oe && inh_cnt == 0, "R1", "quiet without strobe",
        {busy, ps2_clk_oe}, 0);
  endtask

  task automatic t_busy;
    send(8'h3C);
    chk(busy, "R2", "busy after strobe", busy, 1);
    begin
      logic [10:0] bits; bit seen;
      dev_respond(11, 1, bits, seen);
    end
    repeat (6) @(negedge clk);
    chk(!busy, "R2", "busy low after done", busy, 0);
  endtask

  task automatic t_ignore;
    logic [10:0] bits; bit seen; int i0, d0;
    d0 = done_cnt;
    send(8'hAA);
    repeat (10) @(negedge clk);
    send(8'h55);
    dev_respond(11, 1, bits, seen);
    i0 = inh_cnt;
    repeat (3000) @(negedge clk);
    chk(bits[8:1] == 8'hAA, "R13", "byte unchanged by busy strobe", bits[8:1], 8'hAA);
    chk(inh_cnt == i0 && !busy && done_cnt - d0 == 1, "R13", "no second transfer",
        inh_cnt - i0, 0);
  endtask

  task automatic t_nack;
    logic [10:0] bits; bit seen; int d0, e0;
    d0 = done_cnt; e0 = err_cnt;
    send(8'hF4);
    dev_respond(11, 0, bits, seen);
    repeat (6) @(negedge clk);
    chk(err_cnt - e0 == 1 && done_cnt == d0, "R9", "missing ack gives error",
        err_cnt - e0, 1);
  endtask

  task automatic t_req_timeout;
    int n, e0;
    e0 = err_cnt; n = 0;
    send(8'hFF);
    while (err_cnt == e0 && n < 20000) begin @(negedge clk); n++; end
    chk(n >= 14900 && n <= 15100, "R10", "cycles to start timeout", n, 15000);
    @(negedge clk);
    chk(!ps2_clk_oe && !ps2_dat_oe && !busy, "R10", "lines free after timeout",
        {ps2_clk_oe, ps2_dat_oe, busy}, 0);
  endtask

  task automatic t_edge_timeout;
    logic [10:0] bits; bit seen; int n, e0, d0;
    e0 = err_cnt; d0 = done_cnt; n = 0;
    send(8'h12);
    dev_respond(4, 0, bits, seen);
    while (err_cnt == e0 && n < 5000) begin @(negedge clk); n++; end
    chk(n >= 1900 && n <= 2100, "R11", "cycles to edge timeout", n, 1970);
    @(negedge clk);
    chk(!ps2_clk_oe && !ps2_dat_oe && done_cnt == d0, "R11",
        "released without done", {ps2_clk_oe, ps2_dat_oe}, 0);
  endtask

  task automatic t_defer;
    logic [10:0] bits; bit seen; int d0;
    d0 = done_cnt; viol = 0;
    dev_frame_active = 1; dev_dat_low = 1'b1;
    for (int k = 1; k <= 11; k++) begin
      repeat (40) @(negedge clk);
      dev_clk_low = 1'b1;
      if (k == 3) begin tx_data = 8'hED; tx_send = 1'b1; end
      @(negedge clk); tx_send = 1'b0;
      repeat (39) @(negedge clk);
      dev_clk_low = 1'b0;
      dev_dat_low = (k % 3 == 0);
    end
    dev_dat_low = 1'b0;
    repeat (60) @(negedge clk);
    dev_frame_active = 0;
    chk(viol == 0, "R3", "clock driven during device frame", viol, 0);
    dev_respond(11, 1, bits, seen);
    repeat (6) @(negedge clk);
    chk(bits[8:1] == 8'hED && done_cnt - d0 == 1, "R3", "deferred byte sent",
        bits[8:1], 8'hED);
  endtask

  initial begin
    rst_n = 1'b0; tx_data = '0; tx_send = 1'b0;
    dev_clk_low = 1'b0; dev_dat_low = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    full_tx(8'hED);
    full_tx(8'h00);
    full_tx(8'hFF);
    full_tx(8'h01);
    t_busy();
    t_ignore();
    t_nack();
    t_defer();
    t_edge_timeout();
    t_req_timeout();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule